// File: doc/BRIEF.md
# Shared Data Line Mode Controller

This block decides which of two serial protocols may use a shared data line. After reset it grants the line to a one-way streaming engine. That engine shifts data out on rising edges of a slow external stream clock. A falling edge on the clock of a two-wire addressed bus moves the block into a transition state. There it enables the bus slave, which watches for its control byte. At the same time the block counts stream-clock rising edges as a timeout.

If the bus slave reports a matched control byte while the block is in the transition state, the block locks into bidirectional mode. Only reset clears that lock. If the count reaches its limit while the bus clock rests high, the bus attempt is abandoned. The block returns to streaming and sends a one-cycle restart pulse, so the streaming engine begins again at the top bit of address zero. Every bus clock fall during the transition state clears the count.

Both clocks arrive as levels that are already synchronous to `clk`. All outputs are registered.

Top module: `dual_mode_arbiter`

## Requirements
- R1: While `rst` is high, and in the cycles after it falls, `mode_state` reads 0 (streaming), `strm_drive_en` is 1, `bus_en` is 0 and `strm_restart` is 0.
- R2: In streaming, a high-to-low change of `bus_scl` moves `mode_state` to 1 (transition). In the same cycle `strm_drive_en` falls and `bus_en` rises.
- R3: In transition, every high-to-low change of `bus_scl` clears the stream-pulse count to zero. A full `TIMEOUT` of new stream-clock rising edges is then needed before the timeout.
- R4: In transition, once `TIMEOUT` (default 128) stream-clock rising edges have been counted while `bus_scl` is high, `mode_state` returns to 0. `strm_restart` pulses high for exactly one cycle, and `strm_drive_en` returns to 1.
- R5: While `bus_scl` is held low, the block stays in transition even after the count has reached `TIMEOUT`. The return to streaming happens once `bus_scl` is high again.
- R6: A `ctrl_match` pulse in transition moves `mode_state` to 2 (bidirectional), with `bus_en` high.
- R7: Once in bidirectional mode, neither `bus_scl` edges nor stream-clock edges change the mode. Only `rst` returns it to 0.
- R8: `strm_tick` gives one pulse per stream-clock rising edge only while in streaming. In transition and in bidirectional mode it stays low.
- R9: A `ctrl_match` pulse in streaming has no effect, and `mode_state` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| strm_clk | input | 1 | Synchronized stream clock level |
| bus_scl | input | 1 | Synchronized bus clock level, idle high |
| ctrl_match | input | 1 | One-cycle pulse from the bus slave on a matched control byte |
| mode_state | output | 2 | 0 streaming, 1 transition, 2 bidirectional |
| strm_restart | output | 1 | One-cycle pulse that restarts streaming at address zero |
| strm_tick | output | 1 | Forwarded stream-clock rising edge, valid in streaming only |
| strm_drive_en | output | 1 | Streaming engine may drive the data line |
| bus_en | output | 1 | Bus slave enable |

## Verification
The following rules are checked by assertions on every cycle:
- the bidirectional lock holds;
- a bus clock fall in streaming always leads to the transition state;
- no return to streaming happens while the bus clock is low;
- a restart pulse appears only on a transition-to-streaming step;
- the pulse count is cleared by a bus clock fall and never exceeds its limit.

Some behaviour can only be shown by the bench scenarios:
- the exact number of stream edges needed for a timeout;
- a count cleared partway through and then rebuilt;
- the return to streaming once a held-low bus clock is released;
- the silence of the forwarded stream tick outside streaming.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  typedef enum logic [1:0] {
    MD_STREAM  = 2'd0,
    MD_TRANSIT = 2'd1,
    MD_BIDIR   = 2'd2
  } mode_t;
endpackage

// File: rtl/dmt_edge_det.sv
module dmt_edge_det #(
  parameter bit INIT    = 1'b0,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= INIT;
    else     prev_q <= lvl_i;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = prev_q & ~lvl_i;
    end else begin : g_rise
      assign edge_o = ~prev_q & lvl_i;
    end
  endgenerate
endmodule

// File: rtl/dmt_pulse_cnt.sv
module dmt_pulse_cnt #(
  parameter int CNT_W = 8,
  parameter int LIMIT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !arm_i || clr_i) cnt_q <= '0;
    else if (inc_i && cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == LIM_V);

  // R3: a bus clock fall while armed leaves the count at zero
  a_r3_clear_on_fall: assert property (@(posedge clk) disable iff (rst)
    (arm_i && clr_i) |=> (cnt_q == '0));

  // R4: the count saturates at its limit
  a_r4_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM_V);
endmodule

// File: rtl/dmt_mode_fsm.sv
module dmt_mode_fsm
  import dmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  scl_fall_i,
  input  logic  scl_idle_i,
  input  logic  strm_rise_i,
  input  logic  match_i,
  input  logic  hit_i,
  output mode_t mode_o,
  output logic  restart_o,
  output logic  tick_o,
  output logic  drive_o,
  output logic  bus_en_o
);
  mode_t st_q, st_n;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      MD_STREAM:  if (scl_fall_i) st_n = MD_TRANSIT;
      MD_TRANSIT: begin
        if (match_i)                  st_n = MD_BIDIR;
        else if (hit_i && scl_idle_i) st_n = MD_STREAM;
      end
      MD_BIDIR:   st_n = MD_BIDIR;
      default:    st_n = MD_STREAM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= MD_STREAM;
      restart_o <= 1'b0;
      tick_o    <= 1'b0;
      drive_o   <= 1'b1;
      bus_en_o  <= 1'b0;
    end else begin
      st_q      <= st_n;
      restart_o <= (st_q == MD_TRANSIT) && (st_n == MD_STREAM);
      tick_o    <= (st_q == MD_STREAM) && (st_n == MD_STREAM) && strm_rise_i;
      drive_o   <= (st_n == MD_STREAM);
      bus_en_o  <= (st_n != MD_STREAM);
    end
  end

  assign mode_o = st_q;

  // R2: bus clock fall in streaming leads to transition
  a_r2_fall_enters: assert property (@(posedge clk) disable iff (rst)
    (st_q == MD_STREAM && scl_fall_i) |=> (st_q == MD_TRANSIT));

  // R5: no return to streaming while the bus clock is low
  a_r5_no_exit_busy: assert property (@(posedge clk) disable iff (rst)
    (st_q == MD_TRANSIT && !scl_idle_i) |=> (st_q != MD_STREAM));

  // R4: restart only on a transition-to-streaming step
  a_r4_restart_src: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> (st_q == MD_STREAM && $past(st_q) == MD_TRANSIT));

  // R7: bidirectional mode is held until reset
  a_r7_bidir_hold: assert property (@(posedge clk) disable iff (rst)
    (st_q == MD_BIDIR) |=> (st_q == MD_BIDIR));

  // R9: streaming is left only through a bus clock fall
  a_r9_match_ignored: assert property (@(posedge clk) disable iff (rst)
    (st_q == MD_STREAM && !scl_fall_i) |=> (st_q == MD_STREAM));

  // R8: forwarded ticks only appear in streaming
  a_r8_tick_stream: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (st_q == MD_STREAM));
endmodule

// File: rtl/dual_mode_arbiter.sv
module dual_mode_arbiter
  import dmt_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int TIMEOUT = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strm_clk,
  input  logic       bus_scl,
  input  logic       ctrl_match,
  output logic [1:0] mode_state,
  output logic       strm_restart,
  output logic       strm_tick,
  output logic       strm_drive_en,
  output logic       bus_en
);
  mode_t mode_w;
  logic  scl_fall, strm_rise, cnt_hit;

  dmt_edge_det #(.INIT(1'b1), .FALLING(1'b1)) u_scl_edge (
    .clk(clk), .rst(rst), .lvl_i(bus_scl), .edge_o(scl_fall)
  );

  dmt_edge_det #(.INIT(1'b0), .FALLING(1'b0)) u_strm_edge (
    .clk(clk), .rst(rst), .lvl_i(strm_clk), .edge_o(strm_rise)
  );

  dmt_pulse_cnt #(.CNT_W(CNT_W), .LIMIT(TIMEOUT)) u_cnt (
    .clk(clk), .rst(rst),
    .arm_i(mode_w == MD_TRANSIT),
    .clr_i(scl_fall),
    .inc_i(strm_rise),
    .hit_o(cnt_hit)
  );

  dmt_mode_fsm u_fsm (
    .clk(clk), .rst(rst),
    .scl_fall_i(scl_fall),
    .scl_idle_i(bus_scl),
    .strm_rise_i(strm_rise),
    .match_i(ctrl_match),
    .hit_i(cnt_hit),
    .mode_o(mode_w),
    .restart_o(strm_restart),
    .tick_o(strm_tick),
    .drive_o(strm_drive_en),
    .bus_en_o(bus_en)
  );

  assign mode_state = mode_w;
endmodule

// File: tb/tb_dual_mode_arbiter.sv
`timescale 1ns/1ps
module tb_dual_mode_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strm_clk = 1'b0;
  logic       bus_scl = 1'b1;
  logic       ctrl_match = 1'b0;
  logic [1:0] mode_state;
  logic       strm_restart, strm_tick, strm_drive_en, bus_en;

  int n_cmp = 0, n_bad = 0;
  int n_restart = 0, n_tick = 0;
  logic [1:0] exp_q[$];
  logic [1:0] last_mode = 2'd0;
  bit mon_en = 0;

  always #2.5 clk = ~clk;

  dual_mode_arbiter dut (
    .clk(clk), .rst(rst), .strm_clk(strm_clk), .bus_scl(bus_scl),
    .ctrl_match(ctrl_match), .mode_state(mode_state),
    .strm_restart(strm_restart), .strm_tick(strm_tick),
    .strm_drive_en(strm_drive_en), .bus_en(bus_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops an expected mode for each observed mode change
  always @(negedge clk) begin
    if (mon_en) begin
      if (strm_restart) n_restart++;
      if (strm_tick)    n_tick++;
      if (mode_state != last_mode) begin
        if (exp_q.size() == 0) check("mode change unexpected", int'(mode_state), int'(last_mode));
        else check("mode sequence", int'(mode_state), int'(exp_q.pop_front()));
        last_mode = mode_state;
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strm_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      strm_clk = 1'b1; cyc(3);
      strm_clk = 1'b0; cyc(3);
    end
  endtask

  task automatic scl_dip();
    bus_scl = 1'b0; cyc(4);
    bus_scl = 1'b1; cyc(4);
  endtask

  task automatic expect_mode(input logic [1:0] m);
    exp_q.push_back(m);
  endtask

  initial begin
    cyc(3);
    // R1: reset state
    check("R1 mode", int'(mode_state), 0);
    check("R1 drive", int'(strm_drive_en), 1);
    check("R1 bus_en", int'(bus_en), 0);
    rst = 1'b0;
    mon_en = 1;
    cyc(3);
    check("R1 mode after release", int'(mode_state), 0);
    check("R1 restart", n_restart, 0);

    // R8: ticks forwarded in streaming
    strm_pulses(3); cyc(3);
    check("R8 ticks in streaming", n_tick, 3);

    // R9: match ignored in streaming
    ctrl_match = 1'b1; cyc(1); ctrl_match = 1'b0; cyc(4);
    check("R9 mode", int'(mode_state), 0);

    // R2: enter transition
    expect_mode(2'd1);
    scl_dip();
    check("R2 mode", int'(mode_state), 1);
    check("R2 bus_en", int'(bus_en), 1);
    check("R2 drive", int'(strm_drive_en), 0);

    // R3: clear mid-count, then full count needed
    strm_pulses(100);
    scl_dip();
    strm_pulses(127); cyc(4);
    check("R3 still transit after 127", int'(mode_state), 1);
    check("R8 no ticks in transit", n_tick, 3);
    // R4: 128th pulse triggers timeout
    expect_mode(2'd0);
    strm_pulses(1); cyc(4);
    check("R4 mode", int'(mode_state), 0);
    check("R4 restart pulses", n_restart, 1);
    check("R4 drive", int'(strm_drive_en), 1);

    // R5: held-low bus clock blocks timeout
    expect_mode(2'd1);
    bus_scl = 1'b0; cyc(4);
    strm_pulses(130); cyc(4);
    check("R5 held low stays transit", int'(mode_state), 1);
    expect_mode(2'd0);
    bus_scl = 1'b1; cyc(5);
    check("R5 release returns", int'(mode_state), 0);
    check("R5 restart pulses", n_restart, 2);

    // R6: matched control byte locks bidirectional
    expect_mode(2'd1);
    scl_dip();
    strm_pulses(10);
    expect_mode(2'd2);
    ctrl_match = 1'b1; cyc(1); ctrl_match = 1'b0; cyc(4);
    check("R6 mode", int'(mode_state), 2);
    check("R6 bus_en", int'(bus_en), 1);

    // R7: sticky against bus clock and stream activity
    scl_dip(); scl_dip(); scl_dip();
    strm_pulses(200); cyc(4);
    check("R7 mode held", int'(mode_state), 2);
    check("R8 no ticks in bidir", n_tick, 3);
    check("R7 restart count", n_restart, 2);

    // R7: reset is the only way back
    expect_mode(2'd0);
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(3);
    check("R7 reset returns", int'(mode_state), 0);
    check("scoreboard drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #150000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule